// File: doc/BRIEF.md
# Receive Frame Filer Rule Engine

The block decides what happens to each received frame. An earlier parsing stage extracts sixteen 32-bit properties from the frame and hands them over with a start strobe. The engine then walks a 256-entry rule table from entry 0 upward, one entry per clock. It stops at the first rule set that succeeds, and that rule set either discards the frame or files it to one of 64 receive queues. Each entry holds a 16-bit control word and a 32-bit comparison value. Software loads the entries through a simple write port.

Rules can be combined. A conjunctive entry must match before the search moves on, and only the closing non-conjunctive entry of the chain names the outcome. A guard entry with the cluster flag set lets a failing test skip a whole group of entries. Every decision comes out as a one-cycle result that carries a two-bit error code. The code tells a clean decision apart from a filing to a disabled queue, a search that was cut short, and a search with no match at all. A separate pulse marks accepted frames whose rule asks for a general-purpose interrupt.

Top module: `frame_filer`

## Requirements
- R1: After reset, `dec_valid` and `gpi_pulse` are low. Every table entry holds an always-failing rule (control 0x0060, value 0).
- R2: Control word fields are: property select in bits 3:0, interrupt request in bit 4, compare code in bits 6:5, conjunction in bit 7, reject in bit 8, cluster flag in bit 9 and queue in bits 15:10. The compare codes test the selected property against the entry value as follows: 00 is unsigned greater-or-equal, 01 is less-or-equal, 10 is equal and 11 is less-than.
- R3: Entries are evaluated in ascending order. The first successful rule set decides. A frame decided by entry k produces `dec_valid` k+1 clocks after the edge that samples `frm_start`.
- R4: An entry with the conjunction bit set must match, and then the next entry is evaluated. A chain succeeds only if its closing entry (conjunction clear) also matches. If any term fails, the chain fails up to and including its closing entry.
- R5: A successful rule with the reject bit set discards the frame. The error code is 00 and no interrupt pulse is given.
- R6: A conjunctive entry with the cluster flag set that fails skips every entry up to and including the next entry that has the cluster flag set.
- R7: If entry 255 is passed without success, the frame is filed to queue 0 with error code 11.
- R8: A nonzero `budget` limits the search to that many entries. If the last allowed entry does not decide, the frame goes to queue 0 with error code 10. A budget of 0 means no limit.
- R9: A `frm_start` during a search ends that search at once. On the next clock, `dec_valid` is given with queue 0 and error code 10, and the new frame starts at entry 0.
- R10: A frame accepted to a queue whose bit in `q_enable` is 0 keeps that queue number and reports error code 01.
- R11: With `filer_en` low, a frame is filed to queue 0 two clocks after its start. The error code is 01 if bit 0 of `q_enable` is clear, and 00 otherwise.
- R12: `gpi_pulse` is high for exactly the cycle of `dec_valid`, and only when the deciding rule has the interrupt bit set and the reject bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| filer_en | input | 1 | Search enable; low sends frames to queue 0 |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Entry written |
| tbl_ctrl | input | 16 | Control word written |
| tbl_value | input | 32 | Comparison value written |
| frm_start | input | 1 | New frame; properties are sampled on this edge |
| frm_props | input | 512 | Sixteen 32-bit properties, property n in bits 32n+31:32n |
| q_enable | input | 64 | Per-queue enable mask |
| budget | input | 16 | Entries allowed per frame, 0 = unlimited |
| dec_valid | output | 1 | Decision strobe |
| dec_reject | output | 1 | Frame discarded |
| dec_queue | output | 6 | Destination queue |
| dec_err | output | 2 | Error code |
| gpi_pulse | output | 1 | Interrupt request for an accepted frame |

## Verification
Several properties are checked on every cycle: every no-match and partial outcome lands on queue 0, a discard never carries an error code, the interrupt pulse only appears alongside an accepted decision, and a decision is only given after an active search. The ordering of entries, the chain and cluster semantics, the compare codes, the exact decision latency, the budget cut-off and the abort on a new frame all depend on table contents and timing. Only the bench's directed table setups can show these.

// File: rtl/filer_pkg.sv
package filer_pkg;
    localparam int NPROPS  = 16;
    localparam int QUEUES  = 64;
    localparam int QID_W   = $clog2(QUEUES);
    localparam int PID_W   = $clog2(NPROPS);

    typedef enum logic [1:0] {
        CMP_GE = 2'b00,
        CMP_LE = 2'b01,
        CMP_EQ = 2'b10,
        CMP_LT = 2'b11
    } cmp_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_BADQ    = 2'b01,
        ERR_PARTIAL = 2'b10,
        ERR_NOMATCH = 2'b11
    } err_e;

    typedef struct packed {
        logic [QID_W-1:0] queue;
        logic             cle;
        logic             rej;
        logic             conj;
        logic [1:0]       cmp;
        logic             gpi;
        logic [PID_W-1:0] pid;
    } rule_ctrl_t;

    localparam int CTRL_W = $bits(rule_ctrl_t);
endpackage

// File: rtl/filer_table.sv
module filer_table
    import filer_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int PROP_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  rule_ctrl_t        wr_ctrl,
    input  logic [PROP_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output rule_ctrl_t        rd_ctrl,
    output logic [PROP_W-1:0] rd_val
);
    typedef struct packed {
        rule_ctrl_t        ctrl;
        logic [PROP_W-1:0] val;
    } entry_t;

    localparam rule_ctrl_t FAIL_CTRL = '{queue: '0, cle: 1'b0, rej: 1'b0,
                                         conj: 1'b0, cmp: CMP_LT, gpi: 1'b0,
                                         pid: '0};

    entry_t tbl_d [ENTRIES];
    entry_t tbl_q [ENTRIES];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = '{ctrl: wr_ctrl, val: wr_val};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= '{ctrl: FAIL_CTRL, val: '0};
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ctrl = tbl_q[rd_idx].ctrl;
    assign rd_val  = tbl_q[rd_idx].val;
endmodule

// File: rtl/filer_match.sv
module filer_match
    import filer_pkg::*;
#(
    parameter int PROP_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NPROPS*PROP_W-1:0] props_in,
    input  logic [PID_W-1:0]         pid,
    input  logic [1:0]               cmp,
    input  logic [PROP_W-1:0]        val,
    output logic                     hit
);
    logic [NPROPS*PROP_W-1:0] props_d, props_q;
    logic [PROP_W-1:0]        lane [NPROPS];
    logic [PROP_W-1:0]        sel;

    always_comb begin
        props_d = props_q;
        if (load) props_d = props_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) props_q <= '0;
        else        props_q <= props_d;
    end

    for (genvar g = 0; g < NPROPS; g++) begin : g_lane
        assign lane[g] = props_q[g*PROP_W +: PROP_W];
    end

    assign sel = lane[pid];

    always_comb begin
        unique case (cmp_e'(cmp))
            CMP_GE:  hit = (sel >= val);
            CMP_LE:  hit = (sel <= val);
            CMP_EQ:  hit = (sel == val);
            CMP_LT:  hit = (sel <  val);
            default: hit = 1'b0;
        endcase
    end

    // R2
    eq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == CMP_EQ && hit) |-> (lane[pid] == val));
endmodule

// File: rtl/filer_seq.sv
module filer_seq
    import filer_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int BUD_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filer_en,
    input  logic              frm_start,
    input  logic [QUEUES-1:0] q_enable,
    input  logic [BUD_W-1:0]  budget,
    input  logic              r_conj,
    input  logic              r_rej,
    input  logic              r_cle,
    input  logic              r_gpi,
    input  logic [QID_W-1:0]  r_queue,
    input  logic              r_hit,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              dec_valid,
    output logic              dec_reject,
    output logic [QID_W-1:0]  dec_queue,
    output logic [1:0]        dec_err,
    output logic              gpi_pulse
);
    localparam int LAST = ENTRIES - 1;

    typedef struct packed {
        logic             busy;
        logic             bypass;
        logic             chain_bad;
        logic             skipping;
        logic [IDX_W-1:0] idx;
        logic             dvalid;
        logic             drej;
        logic [QID_W-1:0] dq;
        logic [1:0]       derr;
        logic             dgpi;
    } st_t;

    st_t s_d, s_q;

    logic             c_fire, c_rej, c_gpi;
    logic [QID_W-1:0] c_q;
    err_e             c_err;
    logic             at_last, budget_out;

    always_comb begin
        s_d        = s_q;
        s_d.dvalid = 1'b0;
        s_d.dgpi   = 1'b0;
        c_fire     = 1'b0;
        c_rej      = 1'b0;
        c_gpi      = 1'b0;
        c_q        = '0;
        c_err      = ERR_NONE;
        at_last    = (int'(s_q.idx) == LAST);
        budget_out = (budget != '0) && ((int'(s_q.idx) + 1) == int'(budget));

        if (s_q.busy) begin
            if (s_q.bypass) begin
                c_fire = 1'b1;
                c_err  = q_enable[0] ? ERR_NONE : ERR_BADQ;
            end else begin
                if (s_q.skipping) begin
                    if (r_cle) s_d.skipping = 1'b0;
                end else if (s_q.chain_bad) begin
                    if (!r_conj) s_d.chain_bad = 1'b0;
                end else if (r_conj) begin
                    if (!r_hit) begin
                        if (r_cle) s_d.skipping  = 1'b1;
                        else       s_d.chain_bad = 1'b1;
                    end
                end else if (r_hit) begin
                    c_fire = 1'b1;
                    c_rej  = r_rej;
                    c_q    = r_queue;
                    c_gpi  = r_gpi && !r_rej;
                    c_err  = (!r_rej && !q_enable[r_queue]) ? ERR_BADQ : ERR_NONE;
                end

                if (!c_fire) begin
                    if (at_last) begin
                        c_fire = 1'b1;
                        c_err  = ERR_NOMATCH;
                    end else if (budget_out) begin
                        c_fire = 1'b1;
                        c_err  = ERR_PARTIAL;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
        end

        if (frm_start && s_q.busy && !c_fire) begin
            c_fire = 1'b1;
            c_err  = ERR_PARTIAL;
        end

        if (c_fire) begin
            s_d.busy   = 1'b0;
            s_d.dvalid = 1'b1;
            s_d.drej   = c_rej;
            s_d.dq     = c_q;
            s_d.derr   = c_err;
            s_d.dgpi   = c_gpi;
        end

        if (frm_start) begin
            s_d.busy      = 1'b1;
            s_d.bypass    = !filer_en;
            s_d.idx       = '0;
            s_d.chain_bad = 1'b0;
            s_d.skipping  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_idx     = s_q.idx;
    assign dec_valid  = s_q.dvalid;
    assign dec_reject = s_q.drej;
    assign dec_queue  = s_q.dq;
    assign dec_err    = s_q.derr;
    assign gpi_pulse  = s_q.dgpi;

    // R7
    nomatch_q0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_err == ERR_NOMATCH) |-> (dec_queue == '0 && !dec_reject));

    // R8
    partial_q0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_err == ERR_PARTIAL) |-> (dec_queue == '0 && !dec_reject));

    // R5
    reject_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_reject) |-> (dec_err == ERR_NONE && !gpi_pulse));

    // R12
    gpi_with_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpi_pulse |-> (dec_valid && !dec_reject));

    // R3
    decide_after_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (dec_valid || s_q.busy || $past(frm_start)));
endmodule

// File: rtl/frame_filer.sv
module frame_filer
    import filer_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int PROP_W  = 32,
    parameter int BUD_W   = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     filer_en,
    input  logic                     tbl_we,
    input  logic [IDX_W-1:0]         tbl_addr,
    input  logic [CTRL_W-1:0]        tbl_ctrl,
    input  logic [PROP_W-1:0]        tbl_value,
    input  logic                     frm_start,
    input  logic [NPROPS*PROP_W-1:0] frm_props,
    input  logic [QUEUES-1:0]        q_enable,
    input  logic [BUD_W-1:0]         budget,
    output logic                     dec_valid,
    output logic                     dec_reject,
    output logic [QID_W-1:0]         dec_queue,
    output logic [1:0]               dec_err,
    output logic                     gpi_pulse
);
    logic [IDX_W-1:0]  rd_idx;
    rule_ctrl_t        rd_ctrl;
    logic [PROP_W-1:0] rd_val;
    logic              hit;

    filer_table #(.ENTRIES(ENTRIES), .PROP_W(PROP_W), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_addr),
        .wr_ctrl (rule_ctrl_t'(tbl_ctrl)),
        .wr_val  (tbl_value),
        .rd_idx  (rd_idx),
        .rd_ctrl (rd_ctrl),
        .rd_val  (rd_val)
    );

    filer_match #(.PROP_W(PROP_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frm_start),
        .props_in (frm_props),
        .pid      (rd_ctrl.pid),
        .cmp      (rd_ctrl.cmp),
        .val      (rd_val),
        .hit      (hit)
    );

    filer_seq #(.ENTRIES(ENTRIES), .BUD_W(BUD_W), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .filer_en   (filer_en),
        .frm_start  (frm_start),
        .q_enable   (q_enable),
        .budget     (budget),
        .r_conj     (rd_ctrl.conj),
        .r_rej      (rd_ctrl.rej),
        .r_cle      (rd_ctrl.cle),
        .r_gpi      (rd_ctrl.gpi),
        .r_queue    (rd_ctrl.queue),
        .r_hit      (hit),
        .rd_idx     (rd_idx),
        .dec_valid  (dec_valid),
        .dec_reject (dec_reject),
        .dec_queue  (dec_queue),
        .dec_err    (dec_err),
        .gpi_pulse  (gpi_pulse)
    );
endmodule

// File: tb/frame_filer_test.sv
module frame_filer_test;
    import filer_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         filer_en = 1'b1;
    logic         tbl_we = 1'b0;
    logic [7:0]   tbl_addr = '0;
    logic [15:0]  tbl_ctrl = '0;
    logic [31:0]  tbl_value = '0;
    logic         frm_start = 1'b0;
    logic [511:0] frm_props = '0;
    logic [63:0]  q_enable = '1;
    logic [15:0]  budget = '0;
    logic         dec_valid, dec_reject, gpi_pulse;
    logic [5:0]   dec_queue;
    logic [1:0]   dec_err;

    int checks = 0;
    int failures = 0;
    int o_lat;
    logic o_rej, o_gpi;
    logic [5:0] o_q;
    logic [1:0] o_err;

    frame_filer uut (
        .clk(clk), .rst_n(rst_n), .filer_en(filer_en), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_ctrl(tbl_ctrl), .tbl_value(tbl_value),
        .frm_start(frm_start), .frm_props(frm_props), .q_enable(q_enable),
        .budget(budget), .dec_valid(dec_valid), .dec_reject(dec_reject),
        .dec_queue(dec_queue), .dec_err(dec_err), .gpi_pulse(gpi_pulse)
    );

    always #10 clk = ~clk;

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary_and_end();
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [15:0] c, input logic [31:0] v);
        tbl_we = 1'b1; tbl_addr = addr[7:0]; tbl_ctrl = c; tbl_value = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wipe();
        for (int i = 0; i < 256; i++) put(i, 16'h0060, 32'h0);
    endtask

    function automatic logic [15:0] file_to(input int q);
        return 16'(q << 10) | 16'h0020;
    endfunction

    task automatic set_prop(input int pid, input logic [31:0] v);
        frm_props[pid*32 +: 32] = v;
    endtask

    task automatic run_frame();
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        o_lat = 1;
        while (!dec_valid && o_lat < 400) begin
            @(negedge clk);
            o_lat++;
        end
        o_rej = dec_reject; o_q = dec_queue; o_err = dec_err; o_gpi = gpi_pulse;
    endtask

    task automatic t_reset();
        chk("R1", "dec_valid", dec_valid, 0);
        chk("R1", "gpi_pulse", gpi_pulse, 0);
        run_frame();
        chk("R1", "empty table err", o_err, 3);
    endtask

    task automatic t_compare();
        for (int c = 0; c < 4; c++) begin
            for (int p = 99; p <= 101; p++) begin
                bit m;
                case (c)
                    0: m = (p >= 100);
                    1: m = (p <= 100);
                    2: m = (p == 100);
                    default: m = (p < 100);
                endcase
                put(0, 16'h2800 | 16'(c << 5) | 16'h2, 32'd100);
                put(1, file_to(20), 32'hFFFF_FFFF);
                set_prop(2, 32'(p));
                run_frame();
                chk("R2", $sformatf("code %0d prop %0d queue", c, p), o_q, m ? 10 : 20);
            end
        end
        wipe();
    endtask

    task automatic t_order();
        put(4, file_to(9), 32'hFFFF_FFFF);
        put(6, file_to(11), 32'hFFFF_FFFF);
        run_frame();
        chk("R3", "first winner queue", o_q, 9);
        chk("R3", "latency", o_lat, 6);
        chk("R3", "err", o_err, 0);
        wipe();
    endtask

    task automatic t_and();
        put(0, 16'h00C1, 32'h55);
        put(1, 16'h0C42, 32'h77);
        put(2, file_to(4), 32'hFFFF_FFFF);
        set_prop(1, 32'h55); set_prop(2, 32'h77);
        run_frame();
        chk("R4", "both terms match queue", o_q, 3);
        set_prop(1, 32'h54);
        run_frame();
        chk("R4", "first term fails queue", o_q, 4);
        chk("R4", "first term fails latency", o_lat, 4);
        set_prop(1, 32'h55); set_prop(2, 32'h0);
        run_frame();
        chk("R4", "closing term fails queue", o_q, 4);
        wipe();
    endtask

    task automatic t_reject();
        put(0, 16'h0130, 32'hFFFF_FFFF);
        run_frame();
        chk("R5", "reject", o_rej, 1);
        chk("R5", "err", o_err, 0);
        chk("R5", "no gpi", o_gpi, 0);
        wipe();
    endtask

    task automatic t_cluster();
        put(0, 16'h02C1, 32'h1234);
        put(1, file_to(5), 32'hFFFF_FFFF);
        put(2, 16'h0260, 32'h0);
        put(3, file_to(7), 32'hFFFF_FFFF);
        set_prop(1, 32'h1234);
        run_frame();
        chk("R6", "guard passes queue", o_q, 5);
        set_prop(1, 32'h0);
        run_frame();
        chk("R6", "guard fails queue", o_q, 7);
        chk("R6", "guard fails latency", o_lat, 5);
        wipe();
    endtask

    task automatic t_nomatch();
        q_enable = '1;
        run_frame();
        chk("R7", "queue", o_q, 0);
        chk("R7", "err", o_err, 3);
        chk("R7", "latency", o_lat, 257);
    endtask

    task automatic t_budget();
        budget = 16'd10;
        run_frame();
        chk("R8", "err", o_err, 2);
        chk("R8", "queue", o_q, 0);
        chk("R8", "latency", o_lat, 11);
        put(9, file_to(13), 32'hFFFF_FFFF);
        run_frame();
        chk("R8", "last allowed entry wins", o_q, 13);
        chk("R8", "last allowed entry err", o_err, 0);
        budget = '0;
        wipe();
    endtask

    task automatic t_abort();
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "still searching", dec_valid, 0);
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        chk("R9", "abort strobe", dec_valid, 1);
        chk("R9", "abort err", dec_err, 2);
        chk("R9", "abort queue", dec_queue, 0);
        o_lat = 1;
        @(negedge clk);
        o_lat++;
        while (!dec_valid && o_lat < 400) begin
            @(negedge clk);
            o_lat++;
        end
        chk("R9", "new frame full search latency", o_lat, 257);
        chk("R9", "new frame err", dec_err, 3);
    endtask

    task automatic t_badq();
        put(0, file_to(12), 32'hFFFF_FFFF);
        q_enable = '1; q_enable[12] = 1'b0;
        run_frame();
        chk("R10", "queue kept", o_q, 12);
        chk("R10", "err", o_err, 1);
        q_enable = '1;
        wipe();
    endtask

    task automatic t_disabled();
        put(0, file_to(30), 32'hFFFF_FFFF);
        filer_en = 1'b0;
        run_frame();
        chk("R11", "queue", o_q, 0);
        chk("R11", "err enabled q0", o_err, 0);
        chk("R11", "latency", o_lat, 2);
        q_enable[0] = 1'b0;
        run_frame();
        chk("R11", "err disabled q0", o_err, 1);
        q_enable = '1;
        filer_en = 1'b1;
        wipe();
    endtask

    task automatic t_gpi();
        put(0, file_to(3) | 16'h0010, 32'hFFFF_FFFF);
        run_frame();
        chk("R12", "pulse with decision", o_gpi, 1);
        @(negedge clk);
        chk("R12", "pulse one cycle", gpi_pulse, 0);
        put(0, file_to(3), 32'hFFFF_FFFF);
        run_frame();
        chk("R12", "no pulse without bit", o_gpi, 0);
        wipe();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compare();
        t_order();
        t_and();
        t_reject();
        t_cluster();
        t_nomatch();
        t_budget();
        t_abort();
        t_badq();
        t_disabled();
        t_gpi();
        summary_and_end();
    end
endmodule